// File: doc/BRIEF.md
# Dual-Port Video Frame Memory

This block models a frame memory with two independent consumers. A host reaches the storage through one command port, one byte at a time. A display engine draws pixels from a serial output. The storage is a set of rows, each `ROW_BITS` wide. Every host command first fetches the whole addressed row into a row latch. The cell reads this way are destructive, so the fetched row is then written back, carrying any byte the host changed.

A transfer command uses the same fetch and write-back sequence. At write-back it also copies the entire row latch into a separate circular shift register. From then on, each cycle with the shift enable high moves the serial output one bit further, starting at bit 0 and in increasing bit order. The shift enable is a synchronous enable in the single clock domain. Streaming goes on while the host keeps issuing reads and writes on the command port, so the display path never stalls the host.

Top module: `vram_dual_port`

## Requirements
- R1: After reset, every stored bit reads as 0, `cmd_ready_o` is 1, and `busy_o`, `rvalid_o`, `row_done_o` and `sdata_o` are 0.
- R2: `cmd_op_i` encodes 2'b00 = byte read, 2'b01 = byte write, 2'b10 = row transfer to the shifter, 2'b11 = row refresh. Only a byte read raises `rvalid_o`. A refresh changes no stored data.
- R3: A command is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. In the following cycle `busy_o` is 1 and `cmd_ready_o` is 0. In the cycle after that, `cmd_ready_o` is 1 again.
- R4: A byte read of row r, column c returns bits [8c+7:8c] of row r on `rdata_o`. `rvalid_o` is high for exactly one cycle, which is the cycle after the busy cycle.
- R5: A byte write to row r, column c replaces bits [8c+7:8c] of row r with `cmd_wdata_i` and leaves every other bit of the row unchanged.
- R6: The fetch clears the addressed row in the array. The write-back in the busy cycle always restores it, so repeated reads of a byte return the same value.
- R7: A transfer copies the whole row in one command. Right after the busy cycle, `sdata_o` shows bit 0. A later transfer restarts the output at bit 0 of the new copy.
- R8: Each cycle with `sclk_en_i` high advances `sdata_o` to the next higher bit. After bit `ROW_BITS-1` the output wraps to bit 0, and `row_done_o` is high for one cycle, namely the cycle after the shift that performed the wrap.
- R9: A host write to a row that has already been transferred does not change the serial stream until the next transfer.
- R10: While `sclk_en_i` is low and no transfer completes, `sdata_o` holds its value.
- R11: Shifting continues at full rate in the same cycles in which host commands are fetched and written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Port can accept a command |
| cmd_op_i | input | 2 | Command code (see R2) |
| cmd_row_i | input | ROW_W | Row address |
| cmd_col_i | input | COL_W | Byte column within the row |
| cmd_wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | Read byte valid, one-cycle pulse |
| busy_o | output | 1 | Write-back cycle in progress |
| sclk_en_i | input | 1 | Shift enable, one bit per high cycle |
| sdata_o | output | 1 | Serial video bit |
| row_done_o | output | 1 | Pulse after the serial pointer wraps |

## Verification
If the write-back is missing or points at the wrong row, the array keeps the cleared row. The very next read of that row then returns 0 instead of the expected byte, so the fault shows up within four cycles. A fault in the merge or the byte select shows up as a corrupted neighbour byte or a wrong value on a read-back. A fault in the shifter, such as a wrong load, a wrong direction, a missing hold or a wrong wrap count, gives a serial bit that differs from the transferred snapshot on the first bad pulse. A fault in the wrap count also moves or drops the `row_done_o` pulse, which becomes visible at pulse `ROW_BITS`. Host writes made during streaming expose a shifter that tracks the array rather than its own copy.

// File: rtl/vram_pkg.sv
package vram_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_XFER    = 2'b10,
    OP_REFRESH = 2'b11
  } vram_op_e;
endpackage

// File: rtl/vram_array.sv
module vram_array #(
  parameter int unsigned ROW_BITS = 1024,
  parameter int unsigned NUM_ROWS = 16,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [ROW_W-1:0]    rd_row_i,
  output logic [ROW_BITS-1:0] rd_data_o,
  input  logic                wr_en_i,
  input  logic [ROW_W-1:0]    wr_row_i,
  input  logic [ROW_BITS-1:0] wr_data_i
);
  logic [ROW_BITS-1:0] mem_q [NUM_ROWS];

  assign rd_data_o = mem_q[rd_row_i];

  // destructive sense: fetched row is cleared until restored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ROWS; r++) mem_q[r] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_row_i] <= wr_data_i;
    end else if (rd_en_i) begin
      mem_q[rd_row_i] <= '0;
    end
  end

  // R6
  fetch_then_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (wr_en_i && wr_row_i == $past(rd_row_i)));

  // R6
  single_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && wr_en_i));
endmodule

// File: rtl/vram_ctrl.sv
module vram_ctrl
  import vram_pkg::*;
#(
  parameter int unsigned ROW_BITS = 1024,
  parameter int unsigned NUM_ROWS = 16,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS),
  localparam int unsigned COL_W   = $clog2(ROW_BITS / BYTE_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  vram_op_e            cmd_op_i,
  input  logic [ROW_W-1:0]    cmd_row_i,
  input  logic [COL_W-1:0]    cmd_col_i,
  input  logic [BYTE_W-1:0]   cmd_wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  output logic                rvalid_o,
  output logic                busy_o,
  output logic                arr_rd_en_o,
  output logic [ROW_W-1:0]    arr_rd_row_o,
  input  logic [ROW_BITS-1:0] arr_rd_data_i,
  output logic                arr_wr_en_o,
  output logic [ROW_W-1:0]    arr_wr_row_o,
  output logic [ROW_BITS-1:0] arr_wr_data_o,
  output logic                xfer_o,
  output logic [ROW_BITS-1:0] xfer_data_o
);
  typedef enum logic {ST_IDLE, ST_WB} state_e;

  state_e              state_q;
  vram_op_e            op_q;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q;
  logic [ROW_BITS-1:0] latch_q;
  logic [ROW_BITS-1:0] merged;
  logic                accept;

  assign cmd_ready_o  = (state_q == ST_IDLE);
  assign busy_o       = (state_q == ST_WB);
  assign accept       = cmd_valid_i && cmd_ready_o;
  assign arr_rd_en_o  = accept;
  assign arr_rd_row_o = cmd_row_i;

  // host byte folded into the fetched row before it reaches the latch
  always_comb begin
    merged = arr_rd_data_i;
    if (cmd_op_i == OP_WRITE) merged[int'(cmd_col_i) * BYTE_W +: BYTE_W] = cmd_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_READ;
      row_q   <= '0;
      col_q   <= '0;
      latch_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_WB;
          op_q    <= cmd_op_i;
          row_q   <= cmd_row_i;
          col_q   <= cmd_col_i;
          latch_q <= merged;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arr_wr_en_o   = busy_o;
  assign arr_wr_row_o  = row_q;
  assign arr_wr_data_o = latch_q;
  assign xfer_o        = busy_o && (op_q == OP_XFER);
  assign xfer_data_o   = latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= busy_o && (op_q == OP_READ);
      if (busy_o && (op_q == OP_READ)) rdata_o <= latch_q[int'(col_q) * BYTE_W +: BYTE_W];
    end
  end

  // R3
  accept_to_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (busy_o && !cmd_ready_o));

  // R3
  busy_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o && cmd_ready_o));

  // R4
  rvalid_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(busy_o) && !busy_o));

  // R2
  xfer_no_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !rvalid_o);
endmodule

// File: rtl/vram_shifter.sv
module vram_shifter #(
  parameter int unsigned ROW_BITS = 1024,
  localparam int unsigned PTR_W   = $clog2(ROW_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ROW_BITS-1:0] load_data_i,
  input  logic                shift_i,
  output logic                sdata_o,
  output logic                row_done_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ROW_BITS - 1);

  logic [ROW_BITS-1:0] sreg_q;
  logic [PTR_W-1:0]    ptr_q;

  assign sdata_o = sreg_q[0];

  // rotate so the row is intact again after a full lap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q     <= '0;
      ptr_q      <= '0;
      row_done_o <= 1'b0;
    end else if (load_i) begin
      sreg_q     <= load_data_i;
      ptr_q      <= '0;
      row_done_o <= 1'b0;
    end else if (shift_i) begin
      sreg_q     <= {sreg_q[0], sreg_q[ROW_BITS-1:1]};
      ptr_q      <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      row_done_o <= (ptr_q == LAST);
    end else begin
      row_done_o <= 1'b0;
    end
  end

  // R10
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(sdata_o));

  // R8
  done_needs_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done_o |-> $past(shift_i));

  // R8
  done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done_o |=> !row_done_o);
endmodule

// File: rtl/vram_dual_port.sv
module vram_dual_port
  import vram_pkg::*;
#(
  parameter int unsigned ROW_BITS = 1024,
  parameter int unsigned NUM_ROWS = 16,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS),
  localparam int unsigned COL_W   = $clog2(ROW_BITS / BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [ROW_W-1:0]  cmd_row_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic [BYTE_W-1:0] cmd_wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              busy_o,
  input  logic              sclk_en_i,
  output logic              sdata_o,
  output logic              row_done_o
);
  logic                arr_rd_en, arr_wr_en, xfer;
  logic [ROW_W-1:0]    arr_rd_row, arr_wr_row;
  logic [ROW_BITS-1:0] arr_rd_data, arr_wr_data, xfer_data;

  vram_array #(.ROW_BITS(ROW_BITS), .NUM_ROWS(NUM_ROWS)) i_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (arr_rd_en),
    .rd_row_i (arr_rd_row),
    .rd_data_o(arr_rd_data),
    .wr_en_i  (arr_wr_en),
    .wr_row_i (arr_wr_row),
    .wr_data_i(arr_wr_data)
  );

  vram_ctrl #(.ROW_BITS(ROW_BITS), .NUM_ROWS(NUM_ROWS)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_op_i     (vram_op_e'(cmd_op_i)),
    .cmd_row_i    (cmd_row_i),
    .cmd_col_i    (cmd_col_i),
    .cmd_wdata_i  (cmd_wdata_i),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o),
    .busy_o       (busy_o),
    .arr_rd_en_o  (arr_rd_en),
    .arr_rd_row_o (arr_rd_row),
    .arr_rd_data_i(arr_rd_data),
    .arr_wr_en_o  (arr_wr_en),
    .arr_wr_row_o (arr_wr_row),
    .arr_wr_data_o(arr_wr_data),
    .xfer_o       (xfer),
    .xfer_data_o  (xfer_data)
  );

  vram_shifter #(.ROW_BITS(ROW_BITS)) i_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (xfer),
    .load_data_i(xfer_data),
    .shift_i    (sclk_en_i),
    .sdata_o    (sdata_o),
    .row_done_o (row_done_o)
  );
endmodule

// File: tb/test_vram_dual_port.sv
module test_vram_dual_port;
  localparam int ROW_BITS = 1024;
  localparam int NUM_ROWS = 16;
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int COL_W = $clog2(ROW_BITS / 8);
  localparam int NCOL = ROW_BITS / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [ROW_W-1:0] cmd_row = '0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [7:0] cmd_wdata = '0, rdata;
  logic rvalid, busy, sdata, row_done;
  logic sclk_en = 1'b0;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [ROW_BITS-1:0] ref_mem [NUM_ROWS];
  logic [ROW_BITS-1:0] ref_shift = '0;
  int s_idx = 0;
  logic pend_done = 1'b0;

  always #10 clk = ~clk;

  vram_dual_port #(.ROW_BITS(ROW_BITS), .NUM_ROWS(NUM_ROWS)) i_vram_dual_port (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_row_i(cmd_row), .cmd_col_i(cmd_col), .cmd_wdata_i(cmd_wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .busy_o(busy), .sclk_en_i(sclk_en),
    .sdata_o(sdata), .row_done_o(row_done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int row, input int col);
    return 8'((col * 37 + row * 5 + 11) & 8'hFF);
  endfunction

  // one command; checks the handshake (R3) and the read response (R2, R4)
  task automatic do_cmd(input logic [1:0] op, input int row, input int col,
                        input logic [7:0] wd);
    @(negedge clk);
    chk("R3 ready idle", 32'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = ROW_W'(row); cmd_col = COL_W'(col); cmd_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3 busy", {30'd0, busy, cmd_ready}, 32'b10);
    @(posedge clk);
    @(negedge clk);
    chk("R3 ready back", {30'd0, busy, cmd_ready}, 32'b01);
    chk("R2 rvalid by op", 32'(rvalid), 32'(op == 2'b00));
    if (op == 2'b00)
      chk("R4 read byte", 32'(rdata), 32'(ref_mem[row][col*8 +: 8]));
    if (op == 2'b01) ref_mem[row][col*8 +: 8] = wd;
    if (op == 2'b10) begin
      ref_shift = ref_mem[row]; s_idx = 0; pend_done = 1'b0;
      chk("R7 bit0 after xfer", 32'(sdata), 32'(ref_shift[0]));
    end
    if (op == 2'b00) begin
      @(negedge clk);
      chk("R4 rvalid one cycle", 32'(rvalid), 0);
    end
  endtask

  // streams n enable cycles; every gap-th cycle the enable stays low
  task automatic stream(input int n, input int gap);
    logic held;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R8 serial bit", 32'(sdata), 32'(ref_shift[s_idx]));
      chk("R8 row_done", 32'(row_done), 32'(pend_done));
      if (gap != 0 && (k % gap) == gap - 1) begin
        held = sdata;
        sclk_en = 1'b0;
        pend_done = 1'b0;
        @(negedge clk);
        chk("R10 hold", 32'(sdata), 32'(held));
        chk("R8 no done on hold", 32'(row_done), 0);
      end else begin
        sclk_en = 1'b1;
        pend_done = (s_idx == ROW_BITS - 1);
        s_idx = (s_idx + 1) % ROW_BITS;
      end
    end
    @(negedge clk);
    sclk_en = 1'b0;
    chk("R8 final bit", 32'(sdata), 32'(ref_shift[s_idx]));
    chk("R8 final done", 32'(row_done), 32'(pend_done));
    pend_done = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 outputs", {27'd0, cmd_ready, busy, rvalid, row_done, sdata}, 32'b10000);
    do_cmd(2'b00, 3, 5, 8'h00);
    do_cmd(2'b00, NUM_ROWS - 1, NCOL - 1, 8'h00);
  endtask

  task automatic t_byte_rw;
    do_cmd(2'b01, 2, 0, 8'hA5);
    do_cmd(2'b01, 2, NCOL - 1, 8'h3C);
    do_cmd(2'b01, 2, 64, 8'h81);
    do_cmd(2'b00, 2, 0, 8'h00);
    do_cmd(2'b00, 2, NCOL - 1, 8'h00);
    do_cmd(2'b00, 2, 64, 8'h00);
    // R5 neighbours untouched
    do_cmd(2'b00, 2, 1, 8'h00);
    do_cmd(2'b00, 2, 63, 8'h00);
    do_cmd(2'b00, 2, 65, 8'h00);
    do_cmd(2'b01, 2, 64, 8'h7E);
    do_cmd(2'b00, 2, 64, 8'h00);
  endtask

  task automatic t_persist;
    // R6 repeated reads and R2 refresh keep data
    do_cmd(2'b00, 2, 0, 8'h00);
    do_cmd(2'b00, 2, 0, 8'h00);
    do_cmd(2'b11, 2, 0, 8'hFF);
    do_cmd(2'b00, 2, 0, 8'h00);
    do_cmd(2'b00, 2, 64, 8'h00);
  endtask

  task automatic fill_row(input int row);
    for (int c = 0; c < NCOL; c++) do_cmd(2'b01, row, c, pat(row, c));
  endtask

  task automatic t_stream;
    fill_row(5);
    do_cmd(2'b10, 5, 0, 8'h00);   // R7
    stream(ROW_BITS + 40, 7);     // R8 wrap, R10 gaps
  endtask

  task automatic t_concurrent;
    fill_row(9);
    do_cmd(2'b10, 9, 0, 8'h00);
    fork
      stream(ROW_BITS + 4, 0);    // R11 full-rate shifting
      begin
        // R9 rewrite the transferred row while it streams
        for (int c = 0; c < NCOL; c += 3) do_cmd(2'b01, 9, c, ~pat(9, c));
        do_cmd(2'b00, 2, 0, 8'h00);
        do_cmd(2'b00, 9, 3, 8'h00);
      end
    join
    do_cmd(2'b00, 9, 0, 8'h00);
    do_cmd(2'b00, 9, 1, 8'h00);
  endtask

  task automatic t_restart;
    do_cmd(2'b10, 5, 0, 8'h00);
    stream(300, 0);
    do_cmd(2'b10, 9, 0, 8'h00);   // R7 restart at bit 0 of new copy
    stream(ROW_BITS + 2, 0);
  endtask

  initial begin
    for (int r = 0; r < NUM_ROWS; r++) ref_mem[r] = '0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk("R1 in reset", {30'd0, busy, rvalid}, 0);
    rst_n = 1'b1;
    t_reset();
    t_byte_rw();
    t_persist();
    t_stream();
    t_concurrent();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule